// File: doc/BRIEF.md
# Pipelined Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary32 words (1 sign bit, 8 exponent bits, 23 fraction bits) in a three-stage pipeline that accepts a new operation every clock. The first stage sorts out special operands and forms the full 24x24 mantissa product together with the biased exponent sum. The second stage normalizes the product with at most one shift. The third stage rounds to nearest with ties to even and packs the word.

Special values follow one fixed policy. Any NaN operand gives the single canonical quiet NaN 32'h7FC00000. A subnormal operand is never used in arithmetic. It gives the canonical NaN, and when the exception-enable input is high it also raises the denormal-operand flag. Results that would be subnormal become a zero of the correct sign. Results that exceed the largest finite exponent become a signed infinity. Each outcome reports a status flag.

Top module: `fpmul_core`

## Requirements
- R1: For two normal operands with a normal result, the output is the product rounded to nearest, ties to even, with sign equal to the XOR of the operand signs and all four flags clear.
- R2: When the mantissa product is 2.0 or more, the result is renormalized by one position and the exponent is increased by one (for example 1.5 x 1.5 = 32'h40100000).
- R3: If either operand is a NaN (exponent 8'hFF, fraction nonzero), the result is 32'h7FC00000 with all flags clear. This is checked before every other case, and it holds whatever the exception-enable input is.
- R4: If no operand is a NaN and either operand is subnormal (exponent 0, fraction nonzero), the result is 32'h7FC00000. The denormal flag is set only when exc_en is 1. This case takes precedence over the infinity and zero cases.
- R5: Infinity times zero gives 32'h7FC00000 with the invalid flag set.
- R6: Infinity times a finite nonzero normal value, or times infinity, gives an infinity whose sign is the XOR of the operand signs, with no flag.
- R7: A zero operand times a finite value gives a zero whose sign is the XOR of the operand signs, with no flag.
- R8: If the biased exponent after rounding is 255 or more, the result is a signed infinity (exponent 8'hFF, fraction 0) and flag_overflow is set.
- R9: If the biased exponent after rounding is 0 or less, the result is a signed zero and flag_underflow is set.
- R10: out_valid equals in_valid delayed by exactly three clock cycles, and back-to-back operations each produce their own result.
- R11: Synchronous active-low reset clears the valid pipeline, so out_valid is 0 during reset and for three cycles after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| exc_en | input | 1 | Exception enable; selects whether a subnormal operand raises the denormal flag |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | Result present this cycle |
| result | output | 32 | binary32 product |
| flag_invalid | output | 1 | Infinity times zero |
| flag_overflow | output | 1 | Result replaced by infinity |
| flag_underflow | output | 1 | Result flushed to zero |
| flag_denorm | output | 1 | Subnormal operand seen while exceptions are enabled |

## Verification
Exact products such as 2 x 3 and -1.5 x 2 exercise the sign and exponent path. Two tie cases, one whose kept bit is odd and one whose kept bit is even, separate correct ties-to-even rounding from truncation and from round-half-up. The 1.5 x 1.5 case exercises the normalizing shift. Operand pairs that mix NaN, subnormal, infinity and zero show the precedence between the special cases and the effect of exc_en. Values near the top and bottom of the exponent range separate overflow from underflow and check the sign of each. Back-to-back issue, a single isolated operation and a reset during flight show the three-cycle timing and the clearing of the valid pipeline.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int PROD_W  = 2 * MANT_W;
    localparam int EXPI_W  = EXP_W + 2;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;

    localparam logic signed [EXPI_W-1:0] EXPI_MAX  = EXPI_W'(EXP_MAX);
    localparam logic signed [EXPI_W-1:0] EXPI_BIAS = EXPI_W'(BIAS);
    localparam logic signed [EXPI_W-1:0] EXPI_ZERO = '0;

    localparam logic [WORD_W-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef struct packed {
        logic invalid;
        logic overflow;
        logic underflow;
        logic denorm;
    } flags_t;

    typedef struct packed {
        logic              is_zero;
        logic              is_inf;
        logic              is_nan;
        logic              is_sub;
        logic [MANT_W-1:0] mant;
    } opcls_t;

    typedef struct packed {
        logic                     valid;
        logic                     special;
        logic [WORD_W-1:0]        spec_res;
        flags_t                   spec_flags;
        logic                     sign;
        logic signed [EXPI_W-1:0] exp_sum;
        logic [PROD_W-1:0]        prod;
    } stage1_t;

    typedef struct packed {
        logic                     valid;
        logic                     special;
        logic [WORD_W-1:0]        spec_res;
        flags_t                   spec_flags;
        logic                     sign;
        logic signed [EXPI_W-1:0] exp_n;
        logic [FRAC_W-1:0]        frac;
        logic                     guard;
        logic                     sticky;
    } stage2_t;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] res;
        flags_t            flags;
    } stage3_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output opcls_t            cls,
    output logic [EXP_W-1:0]  exp_f
);
    logic [FRAC_W-1:0] frac_f;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    always_comb begin
        exp_f       = word[WORD_W-2 -: EXP_W];
        frac_f      = word[FRAC_W-1:0];
        exp_ones    = &exp_f;
        exp_zero    = ~|exp_f;
        frac_zero   = ~|frac_f;
        cls.is_zero = exp_zero & frac_zero;
        cls.is_sub  = exp_zero & ~frac_zero;
        cls.is_inf  = exp_ones & frac_zero;
        cls.is_nan  = exp_ones & ~frac_zero;
        cls.mant    = {~exp_zero, frac_f};
    end
endmodule

// File: rtl/fpm_normalize.sv
module fpm_normalize
    import fpm_pkg::*;
(
    input  logic [PROD_W-1:0]        prod,
    input  logic signed [EXPI_W-1:0] exp_in,
    output logic [FRAC_W-1:0]        frac,
    output logic                     guard,
    output logic                     sticky,
    output logic signed [EXPI_W-1:0] exp_out
);
    always_comb begin
        if (prod[PROD_W-1]) begin
            frac    = prod[PROD_W-2 -: FRAC_W];
            guard   = prod[PROD_W-2-FRAC_W];
            sticky  = |prod[PROD_W-3-FRAC_W:0];
            exp_out = exp_in + EXPI_W'(1);
        end else begin
            frac    = prod[PROD_W-3 -: FRAC_W];
            guard   = prod[PROD_W-3-FRAC_W];
            sticky  = |prod[PROD_W-4-FRAC_W:0];
            exp_out = exp_in;
        end
    end
endmodule

// File: rtl/fpm_round_pack.sv
module fpm_round_pack
    import fpm_pkg::*;
(
    input  logic                     sign,
    input  logic signed [EXPI_W-1:0] exp_in,
    input  logic [FRAC_W-1:0]        frac,
    input  logic                     guard,
    input  logic                     sticky,
    output logic [WORD_W-1:0]        word,
    output logic                     ovf,
    output logic                     unf
);
    logic                     inc;
    logic [FRAC_W:0]          sum;
    logic signed [EXPI_W-1:0] exp_r;

    always_comb begin
        inc   = guard & (sticky | frac[0]);
        sum   = {1'b0, frac} + (FRAC_W+1)'(inc);
        exp_r = exp_in + EXPI_W'(sum[FRAC_W]);
        ovf   = 1'b0;
        unf   = 1'b0;
        if (exp_r >= EXPI_MAX) begin
            ovf  = 1'b1;
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (exp_r <= EXPI_ZERO) begin
            unf  = 1'b1;
            word = {sign, {(WORD_W-1){1'b0}}};
        end else begin
            word = {sign, exp_r[EXP_W-1:0], sum[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpmul_core.sv
module fpmul_core
    import fpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              exc_en,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              flag_invalid,
    output logic              flag_overflow,
    output logic              flag_underflow,
    output logic              flag_denorm
);
    opcls_t                   cls_a, cls_b;
    logic [EXP_W-1:0]         ea, eb;
    logic [FRAC_W-1:0]        n_frac;
    logic                     n_guard, n_sticky;
    logic signed [EXPI_W-1:0] n_exp;
    logic [WORD_W-1:0]        r_word;
    logic                     r_ovf, r_unf;

    stage1_t s1_d, s1_q;
    stage2_t s2_d, s2_q;
    stage3_t s3_d, s3_q;

    fpm_unpack unp_a_i (.word(op_a), .cls(cls_a), .exp_f(ea));
    fpm_unpack unp_b_i (.word(op_b), .cls(cls_b), .exp_f(eb));

    fpm_normalize norm_i (
        .prod(s1_q.prod), .exp_in(s1_q.exp_sum),
        .frac(n_frac), .guard(n_guard), .sticky(n_sticky), .exp_out(n_exp)
    );

    fpm_round_pack rnd_i (
        .sign(s2_q.sign), .exp_in(s2_q.exp_n), .frac(s2_q.frac),
        .guard(s2_q.guard), .sticky(s2_q.sticky),
        .word(r_word), .ovf(r_ovf), .unf(r_unf)
    );

    always_comb begin
        // stage 1: classify, multiply mantissas, sum exponents
        s1_d         = '0;
        s1_d.valid   = in_valid;
        s1_d.sign    = op_a[WORD_W-1] ^ op_b[WORD_W-1];
        s1_d.exp_sum = $signed({{(EXPI_W-EXP_W){1'b0}}, ea})
                     + $signed({{(EXPI_W-EXP_W){1'b0}}, eb}) - EXPI_BIAS;
        s1_d.prod    = cls_a.mant * cls_b.mant;
        if (cls_a.is_nan | cls_b.is_nan) begin
            s1_d.special  = 1'b1;
            s1_d.spec_res = CANON_NAN;
        end else if (cls_a.is_sub | cls_b.is_sub) begin
            s1_d.special           = 1'b1;
            s1_d.spec_res          = CANON_NAN;
            s1_d.spec_flags.denorm = exc_en;
        end else if ((cls_a.is_inf & cls_b.is_zero) | (cls_a.is_zero & cls_b.is_inf)) begin
            s1_d.special            = 1'b1;
            s1_d.spec_res           = CANON_NAN;
            s1_d.spec_flags.invalid = 1'b1;
        end else if (cls_a.is_inf | cls_b.is_inf) begin
            s1_d.special  = 1'b1;
            s1_d.spec_res = {s1_d.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (cls_a.is_zero | cls_b.is_zero) begin
            s1_d.special  = 1'b1;
            s1_d.spec_res = {s1_d.sign, {(WORD_W-1){1'b0}}};
        end

        // stage 2: normalize
        s2_d.valid      = s1_q.valid;
        s2_d.special    = s1_q.special;
        s2_d.spec_res   = s1_q.spec_res;
        s2_d.spec_flags = s1_q.spec_flags;
        s2_d.sign       = s1_q.sign;
        s2_d.exp_n      = n_exp;
        s2_d.frac       = n_frac;
        s2_d.guard      = n_guard;
        s2_d.sticky     = n_sticky;

        // stage 3: round and pack
        s3_d       = '0;
        s3_d.valid = s2_q.valid;
        if (s2_q.special) begin
            s3_d.res   = s2_q.spec_res;
            s3_d.flags = s2_q.spec_flags;
        end else begin
            s3_d.res             = r_word;
            s3_d.flags.overflow  = r_ovf;
            s3_d.flags.underflow = r_unf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign out_valid      = s3_q.valid;
    assign result         = s3_q.res;
    assign flag_invalid   = s3_q.flags.invalid;
    assign flag_overflow  = s3_q.flags.overflow;
    assign flag_underflow = s3_q.flags.underflow;
    assign flag_denorm    = s3_q.flags.denorm;
endmodule

// File: rtl/fpmul_chk.sv
module fpmul_chk
    import fpm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              exc_en,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              flag_invalid,
    input logic              flag_overflow,
    input logic              flag_underflow,
    input logic              flag_denorm
);
    logic [1:0] since_rst;
    logic       nan_in;

    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign nan_in = in_valid &
        (((&op_a[WORD_W-2 -: EXP_W]) & (|op_a[FRAC_W-1:0])) |
         ((&op_b[WORD_W-2 -: EXP_W]) & (|op_b[FRAC_W-1:0])));

    assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd3) |-> !out_valid);

    assert_nan_canon_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(nan_in, 3)) |-> (out_valid && result == CANON_NAN));

    assert_denorm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid && flag_denorm) |-> ($past(exc_en, 3) && result == CANON_NAN));

    assert_invalid_nan_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_invalid) |-> (result == CANON_NAN));

    assert_ovf_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_overflow) |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    assert_unf_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && flag_underflow) |-> (result[WORD_W-2:0] == '0));

    assert_flags_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0({flag_invalid, flag_overflow, flag_underflow, flag_denorm}));
endmodule

bind fpmul_core fpmul_chk chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .exc_en(exc_en),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow), .flag_denorm(flag_denorm)
);

// File: tb/fpmul_core_tb_top.sv
`timescale 1ns/1ps
module fpmul_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        exc_en = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_invalid, flag_overflow, flag_underflow, flag_denorm;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    fpmul_core dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .exc_en(exc_en),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result),
        .flag_invalid(flag_invalid), .flag_overflow(flag_overflow),
        .flag_underflow(flag_underflow), .flag_denorm(flag_denorm)
    );

    // {op_a, op_b, exc_en, expected result, expected flags {inv,ovf,unf,den}}
    localparam int NV = 19;
    localparam logic [100:0] VEC [NV] = '{
        {32'h3F800000, 32'h3F800000, 1'b0, 32'h3F800000, 4'b0000},  // R1 1*1
        {32'h40000000, 32'h40400000, 1'b0, 32'h40C00000, 4'b0000},  // R1 2*3
        {32'hBFC00000, 32'h40000000, 1'b0, 32'hC0400000, 4'b0000},  // R1 sign
        {32'h3F800001, 32'h3FC00000, 1'b0, 32'h3FC00002, 4'b0000},  // R1 tie, odd -> up
        {32'h3F800003, 32'h3FC00000, 1'b0, 32'h3FC00004, 4'b0000},  // R1 tie, even -> keep
        {32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40100000, 4'b0000},  // R2 shift
        {32'h7F800001, 32'h3F800000, 1'b0, 32'h7FC00000, 4'b0000},  // R3
        {32'h3F800000, 32'hFFC12345, 1'b1, 32'h7FC00000, 4'b0000},  // R3 exc_en=1
        {32'h7F800001, 32'h00000001, 1'b1, 32'h7FC00000, 4'b0000},  // R3 over subnormal
        {32'h00000001, 32'h3F800000, 1'b0, 32'h7FC00000, 4'b0000},  // R4 disabled
        {32'h00000001, 32'h3F800000, 1'b1, 32'h7FC00000, 4'b0001},  // R4 enabled
        {32'h7F800000, 32'h00000001, 1'b1, 32'h7FC00000, 4'b0001},  // R4 over inf
        {32'h7F800000, 32'h00000000, 1'b0, 32'h7FC00000, 4'b1000},  // R5
        {32'hFF800000, 32'h40000000, 1'b0, 32'hFF800000, 4'b0000},  // R6
        {32'h80000000, 32'h40A00000, 1'b0, 32'h80000000, 4'b0000},  // R7
        {32'h7F000000, 32'h40000000, 1'b0, 32'h7F800000, 4'b0100},  // R8
        {32'h7F7FFFFF, 32'hBF800001, 1'b0, 32'hFF800000, 4'b0100},  // R8 negative
        {32'h80800000, 32'h3F000000, 1'b0, 32'h80000000, 4'b0010},  // R9 negative
        {32'h00800000, 32'h3F000000, 1'b0, 32'h00000000, 4'b0010}   // R9
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [36:0] outs();
        return {out_valid, result, flag_invalid, flag_overflow, flag_underflow, flag_denorm};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R10 watchdog", 64'd0, 64'd1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset state", {63'd0, out_valid}, 64'd0);
        rst_n = 1'b1;

        // table walk, one operation issued per cycle (R10 throughput)
        for (int i = 0; i < NV + 3; i++) begin
            @(negedge clk);
            if (i >= 3) begin
                logic [36:0] exp_o;
                exp_o = {1'b1, VEC[i-3][35:0]};
                check(outs() == exp_o, $sformatf("R1-table vector %0d", i - 3),
                      {27'd0, outs()}, {27'd0, exp_o});
            end
            if (i < NV) begin
                in_valid = 1'b1;
                op_a     = VEC[i][100:69];
                op_b     = VEC[i][68:37];
                exc_en   = VEC[i][36];
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        check(out_valid == 1'b0, "R10 valid drops after stream", {63'd0, out_valid}, 64'd0);

        // isolated operation: exact three-cycle latency (R10)
        in_valid = 1'b1; op_a = 32'h40000000; op_b = 32'h40400000; exc_en = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R10 cycle1", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R10 cycle2", {63'd0, out_valid}, 64'd0);
        @(negedge clk);
        check(out_valid == 1'b1 && result == 32'h40C00000, "R10 cycle3",
              {31'd0, out_valid, result}, {31'd0, 1'b1, 32'h40C00000});
        @(negedge clk);
        check(out_valid == 1'b0, "R10 cycle4", {63'd0, out_valid}, 64'd0);

        // reset while an operation is in flight (R11)
        in_valid = 1'b1; op_a = 32'h3F800000; op_b = 32'h3F800000;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid == 1'b0, $sformatf("R11 flushed cycle %0d", k),
                  {63'd0, out_valid}, 64'd0);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule